// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes responses arriving from the codec link and stores them in a circular buffer in system memory. Every response carries a 32-bit payload, the 4-bit address of the codec that sent it and a flag that marks it as unsolicited. For each stored response the block issues one 64-bit memory write. The payload goes in the lower half of the write. The upper half is a companion word that holds the codec address and the unsolicited flag. The block keeps a hardware write pointer that software reads to find out how far the buffer has been filled.

Software sets the buffer base, a ring size code, a response threshold, a global switch for accepting unsolicited responses, a transfer enable and an interrupt enable. It also has three one-cycle pulses: one returns the pointer to zero, one loads the threshold and one clears the status flag. When the number of stored responses reaches the threshold, a sticky status flag is set. The interrupt line is this flag qualified by the interrupt enable. Software can therefore either poll the pointer or wait for the interrupt.

Top module: `resp_ring_writer`

## Requirements
- R1: After reset, `wr_ptr` is 0, `irq_status` and `irq` are 0, `mem_wr_valid` is 0, and `rsp_ready` is 1 while `cfg_dma_en` is 1.
- R2: A stored response produces one memory write. `mem_wr_addr` is `cfg_base + 8*P`, where P is the pointer value after it advances. `mem_wr_data[31:0]` is the payload, `mem_wr_data[35:32]` is the codec address, `mem_wr_data[36]` is the unsolicited flag, and bits 63:37 are zero.
- R3: The pointer always names the last entry written. It advances by one just before each write and wraps at the ring depth. `cfg_size` 0 gives 2 entries, 1 gives 16, and 2 or 3 give 256.
- R4: A pulse on `cfg_wp_reset` sets `wr_ptr` to 0, so the next response is written to entry 1.
- R5: `irq_status` is set on the N-th stored response counted since the last counter restart, where N is `cfg_int_count` and 0 stands for 256. The counter restarts when the flag fires and when `cfg_cnt_wr` loads a new N.
- R6: A pulse on `sts_clear` clears `irq_status`. If a fire and a clear fall in the same cycle, the flag ends up set.
- R7: `irq` is `irq_status` gated by `cfg_irq_en`. Responses are stored whether or not interrupts are enabled.
- R8: When `cfg_accept_unsol` is 0, an unsolicited response is consumed but not written. It neither moves the pointer nor counts toward N.
- R9: When `cfg_dma_en` is 0, `rsp_ready` is 0 and the response waiting at the input is held, not lost. It is stored once transfers are enabled again.
- R10: While `mem_wr_valid` is 1 and `mem_wr_ready` is 0, the pending address and data stay stable and `rsp_ready` is 0.
- R11: `rsp_ready` is 0 in any cycle where `cfg_wp_reset` or `cfg_cnt_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsp_valid | input | 1 | A response is offered |
| rsp_ready | output | 1 | The response is taken this cycle |
| rsp_data | input | 32 | Response payload |
| rsp_codec | input | 4 | Address of the responding codec |
| rsp_unsol | input | 1 | Response is unsolicited |
| cfg_base | input | ADDR_W | Ring base byte address (8-byte aligned) |
| cfg_size | input | 2 | Ring depth code |
| cfg_dma_en | input | 1 | Enables storing responses |
| cfg_irq_en | input | 1 | Enables the interrupt output |
| cfg_accept_unsol | input | 1 | Store unsolicited responses |
| cfg_int_count | input | CNT_W | Response threshold N (0 = 2^CNT_W) |
| cfg_cnt_wr | input | 1 | Pulse: load N and restart the counter |
| cfg_wp_reset | input | 1 | Pulse: set the write pointer to 0 |
| sts_clear | input | 1 | Pulse: clear the status flag |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Byte address of the entry |
| mem_wr_data | output | 64 | Entry: companion word above payload |
| wr_ptr | output | PTR_W | Index of the last written entry |
| irq_status | output | 1 | Sticky threshold-reached flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 32-bit addresses, an 8-bit pointer, an 8-bit threshold counter and the small-ring variant turned on. Because the 2-entry and 16-entry rings are available, pointer wrap can be reached after only a few responses. With an 8-bit counter, the threshold of 0 (meaning 256) is short enough to run to its end. Together with the other cases, this covers counter wrap, simultaneous fire and clear, and memory stalls.

// File: rtl/rrw_pkg.sv
`timescale 1ns/1ps
package rrw_pkg;
   localparam int RESP_W  = 32;
   localparam int CODEC_W = 4;
   localparam int ENTRY_W = 2 * RESP_W;

   typedef struct packed {
      logic [RESP_W-CODEC_W-2:0] rsvd;
      logic                      unsol;
      logic [CODEC_W-1:0]        codec;
   } ext_word_t;

   // index mask for a ring depth code
   function automatic logic [15:0] ring_mask(input logic [1:0] code);
      case (code)
         2'd0:    return 16'd1;
         2'd1:    return 16'd15;
         default: return 16'd255;
      endcase
   endfunction
endpackage

// File: rtl/rrw_ptr.sv
`timescale 1ns/1ps
module rrw_ptr #(
   parameter int PTR_W       = 8,
   parameter bit SMALL_RINGS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       size_code,
   input  logic             clr,
   input  logic             step,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] nxt
);
   logic [PTR_W-1:0] mask;

   generate
      if (SMALL_RINGS) begin : g_table
         assign mask = PTR_W'(rrw_pkg::ring_mask(size_code));
      end else begin : g_full
         logic unused_size;
         assign unused_size = ^size_code;
         assign mask = '1;
      end
   endgenerate

   assign nxt = (ptr + PTR_W'(1)) & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (clr)   ptr <= '0;
      else if (step)  ptr <= nxt;
   end
endmodule

// File: rtl/rrw_irq_count.sv
`timescale 1ns/1ps
module rrw_irq_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] thresh,
   input  logic             hit,
   input  logic             clr,
   output logic             status
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic             fire;

   assign cnt_inc = cnt + CNT_W'(1);
   // threshold 0 matches after the counter wraps, giving 2^CNT_W
   assign fire    = hit && !cnt_load && (cnt_inc == thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (cnt_load || fire) cnt <= '0;
      else if (hit)              cnt <= cnt_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    status <= 1'b0;
      else if (fire) status <= 1'b1;
      else if (clr)  status <= 1'b0;
   end
endmodule

// File: rtl/rrw_entry_out.sv
`timescale 1ns/1ps
module rrw_entry_out #(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [ADDR_W-1:0]           base,
   input  logic [PTR_W-1:0]            slot,
   input  logic [rrw_pkg::RESP_W-1:0]  resp,
   input  rrw_pkg::ext_word_t          ext,
   input  logic                        wr_ready,
   output logic                        wr_valid,
   output logic [ADDR_W-1:0]           wr_addr,
   output logic [rrw_pkg::ENTRY_W-1:0] wr_data,
   output logic                        free
);
   localparam int ENTRY_SHIFT = 3;

   assign free = !wr_valid || wr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wr_valid <= 1'b0;
      else if (load)     wr_valid <= 1'b1;
      else if (wr_ready) wr_valid <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_addr <= '0;
         wr_data <= '0;
      end else if (load) begin
         wr_addr <= base + (ADDR_W'(slot) << ENTRY_SHIFT);
         wr_data <= {ext, resp};
      end
   end
endmodule

// File: rtl/resp_ring_writer.sv
`timescale 1ns/1ps
module resp_ring_writer #(
   parameter int ADDR_W      = 32,
   parameter int PTR_W       = 8,
   parameter int CNT_W       = 8,
   parameter bit SMALL_RINGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [31:0]       rsp_data,
   input  logic [3:0]        rsp_codec,
   input  logic              rsp_unsol,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [1:0]        cfg_size,
   input  logic              cfg_dma_en,
   input  logic              cfg_irq_en,
   input  logic              cfg_accept_unsol,
   input  logic [CNT_W-1:0]  cfg_int_count,
   input  logic              cfg_cnt_wr,
   input  logic              cfg_wp_reset,
   input  logic              sts_clear,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [63:0]       mem_wr_data,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic              irq_status,
   output logic              irq
);
   generate
      if (PTR_W < 8 || PTR_W > 16) begin : g_bad_ptr
         $error("resp_ring_writer: PTR_W must lie in 8..16");
      end
      if (ADDR_W < PTR_W + 3) begin : g_bad_addr
         $error("resp_ring_writer: ADDR_W too narrow for the ring");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("resp_ring_writer: CNT_W must be positive");
      end
   endgenerate

   logic               slot_free;
   logic               take;
   logic               accept_wr;
   logic [PTR_W-1:0]   next_slot;
   rrw_pkg::ext_word_t ext;

   assign rsp_ready = cfg_dma_en && slot_free && !cfg_wp_reset && !cfg_cnt_wr;
   assign take      = rsp_valid && rsp_ready;
   assign accept_wr = take && (!rsp_unsol || cfg_accept_unsol);

   always_comb begin
      ext       = '0;
      ext.codec = rsp_codec;
      ext.unsol = rsp_unsol;
   end

   rrw_ptr #(.PTR_W(PTR_W), .SMALL_RINGS(SMALL_RINGS)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .size_code (cfg_size),
      .clr       (cfg_wp_reset),
      .step      (accept_wr),
      .ptr       (wr_ptr),
      .nxt       (next_slot)
   );

   rrw_entry_out #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept_wr),
      .base     (cfg_base),
      .slot     (next_slot),
      .resp     (rsp_data),
      .ext      (ext),
      .wr_ready (mem_wr_ready),
      .wr_valid (mem_wr_valid),
      .wr_addr  (mem_wr_addr),
      .wr_data  (mem_wr_data),
      .free     (slot_free)
   );

   rrw_irq_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_load (cfg_cnt_wr),
      .thresh   (cfg_int_count),
      .hit      (accept_wr),
      .clr      (sts_clear),
      .status   (irq_status)
   );

   assign irq = irq_status && cfg_irq_en;
endmodule

// File: rtl/rrw_checker.sv
`timescale 1ns/1ps
module rrw_checker #(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic              rsp_unsol,
   input logic              cfg_accept_unsol,
   input logic              cfg_dma_en,
   input logic              cfg_wp_reset,
   input logic              cfg_cnt_wr,
   input logic [ADDR_W-1:0] cfg_base,
   input logic [1:0]        cfg_size,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [63:0]       mem_wr_data,
   input logic [PTR_W-1:0]  wr_ptr,
   input logic              irq_status,
   input logic              take_wr
);
   logic drop_unsol;
   assign drop_unsol = rsp_valid && rsp_ready && rsp_unsol && !cfg_accept_unsol;

   AST_READY_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dma_en |-> !rsp_ready); // R9

   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      take_wr |=> wr_ptr == (($past(wr_ptr) + PTR_W'(1)) & PTR_W'(rrw_pkg::ring_mask($past(cfg_size))))); // R3

   AST_PTR_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wp_reset |=> wr_ptr == '0); // R4

   AST_UNSOL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      drop_unsol && !cfg_wp_reset |=> $stable(wr_ptr)); // R8

   AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R10

   AST_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      take_wr |=> mem_wr_addr == $past(cfg_base) + (ADDR_W'(wr_ptr) << 3)); // R2

   AST_FLAG_FROM_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status) |-> $past(take_wr)); // R5

   AST_READY_GATED_BY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wp_reset || cfg_cnt_wr) |-> !rsp_ready); // R11
endmodule

bind resp_ring_writer rrw_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .rsp_valid        (rsp_valid),
   .rsp_ready        (rsp_ready),
   .rsp_unsol        (rsp_unsol),
   .cfg_accept_unsol (cfg_accept_unsol),
   .cfg_dma_en       (cfg_dma_en),
   .cfg_wp_reset     (cfg_wp_reset),
   .cfg_cnt_wr       (cfg_cnt_wr),
   .cfg_base         (cfg_base),
   .cfg_size         (cfg_size),
   .mem_wr_valid     (mem_wr_valid),
   .mem_wr_ready     (mem_wr_ready),
   .mem_wr_addr      (mem_wr_addr),
   .mem_wr_data      (mem_wr_data),
   .wr_ptr           (wr_ptr),
   .irq_status       (irq_status),
   .take_wr          (accept_wr)
);

// File: tb/sim_resp_ring_writer.sv
`timescale 1ns/1ps
module sim_resp_ring_writer;
   localparam int ADDR_W = 32;
   localparam int PTR_W  = 8;
   localparam int CNT_W  = 8;
   localparam logic [31:0] BASE = 32'h1000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rsp_valid = 1'b0;
   logic              rsp_ready;
   logic [31:0]       rsp_data = '0;
   logic [3:0]        rsp_codec = '0;
   logic              rsp_unsol = 1'b0;
   logic [ADDR_W-1:0] cfg_base = BASE;
   logic [1:0]        cfg_size = 2'd2;
   logic              cfg_dma_en = 1'b1;
   logic              cfg_irq_en = 1'b1;
   logic              cfg_accept_unsol = 1'b1;
   logic [CNT_W-1:0]  cfg_int_count = 8'd1;
   logic              cfg_cnt_wr = 1'b0;
   logic              cfg_wp_reset = 1'b0;
   logic              sts_clear = 1'b0;
   logic              mem_wr_valid;
   logic              mem_wr_ready = 1'b1;
   logic [ADDR_W-1:0] mem_wr_addr;
   logic [63:0]       mem_wr_data;
   logic [PTR_W-1:0]  wr_ptr;
   logic              irq_status;
   logic              irq;

   int n_chk = 0;
   int n_fail = 0;
   int n_wr = 0;
   int exp_wp = 0;
   int depth = 256;

   always #2.5 clk = ~clk;

   always @(posedge clk) if (mem_wr_valid && mem_wr_ready) n_wr <= n_wr + 1;

   resp_ring_writer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .rsp_codec(rsp_codec), .rsp_unsol(rsp_unsol),
      .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_dma_en(cfg_dma_en),
      .cfg_irq_en(cfg_irq_en), .cfg_accept_unsol(cfg_accept_unsol),
      .cfg_int_count(cfg_int_count), .cfg_cnt_wr(cfg_cnt_wr),
      .cfg_wp_reset(cfg_wp_reset), .sts_clear(sts_clear),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .wr_ptr(wr_ptr), .irq_status(irq_status), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] entry(input logic [31:0] d, input logic [3:0] c, input bit u);
      return {27'd0, u, c, d};
   endfunction

   // offer one response; returns at the negedge after it was taken
   task automatic send(input logic [31:0] d, input logic [3:0] c, input bit u, input bit clr);
      @(negedge clk);
      rsp_data = d; rsp_codec = c; rsp_unsol = u; rsp_valid = 1'b1; sts_clear = clr;
      while (!rsp_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0; sts_clear = 1'b0;
   endtask

   task automatic send_chk(input logic [31:0] d, input logic [3:0] c, input bit u, input string tag);
      send(d, c, u, 1'b0);
      exp_wp = (exp_wp + 1) % depth;
      chk(wr_ptr == PTR_W'(exp_wp), {tag, " R3 pointer"}, 64'(wr_ptr), 64'(exp_wp));
      chk(mem_wr_valid == 1'b1, {tag, " R2 write issued"}, 64'(mem_wr_valid), 64'd1);
      chk(mem_wr_addr == BASE + 32'(exp_wp * 8), {tag, " R2 address"}, 64'(mem_wr_addr), 64'(BASE + 32'(exp_wp * 8)));
      chk(mem_wr_data == entry(d, c, u), {tag, " R2 data"}, mem_wr_data, entry(d, c, u));
   endtask

   task automatic pulse_clear();
      @(negedge clk); sts_clear = 1'b1;
      @(negedge clk); sts_clear = 1'b0;
   endtask

   task automatic set_n(input logic [CNT_W-1:0] n);
      @(negedge clk); cfg_int_count = n; cfg_cnt_wr = 1'b1; rsp_valid = 1'b1;
      #0.5 chk(rsp_ready == 1'b0, "R11 ready low on count load", 64'(rsp_ready), 64'd0);
      @(negedge clk); cfg_cnt_wr = 1'b0; rsp_valid = 1'b0;
   endtask

   task automatic reset_ptr();
      @(negedge clk); cfg_wp_reset = 1'b1; rsp_valid = 1'b1;
      #0.5 chk(rsp_ready == 1'b0, "R11 ready low on pointer reset", 64'(rsp_ready), 64'd0);
      @(negedge clk); cfg_wp_reset = 1'b0; rsp_valid = 1'b0;
      chk(wr_ptr == '0, "R4 pointer zero", 64'(wr_ptr), 64'd0);
      exp_wp = 0;
   endtask

   task automatic t_reset();
      chk(wr_ptr == '0, "R1 pointer", 64'(wr_ptr), 64'd0);
      chk(irq_status == 1'b0, "R1 status", 64'(irq_status), 64'd0);
      chk(irq == 1'b0, "R1 irq", 64'(irq), 64'd0);
      chk(mem_wr_valid == 1'b0, "R1 no write", 64'(mem_wr_valid), 64'd0);
      chk(rsp_ready == 1'b1, "R1 ready", 64'(rsp_ready), 64'd1);
   endtask

   task automatic t_basic();
      send_chk(32'hCAFE_0001, 4'd2, 1'b0, "basic0");
      send_chk(32'hDEAD_BEEF, 4'd15, 1'b1, "basic1");
      send_chk(32'h1234_5678, 4'd0, 1'b0, "basic2");
   endtask

   task automatic t_irq_enable();
      cfg_irq_en = 1'b0;
      pulse_clear();
      send_chk(32'h0000_00A5, 4'd3, 1'b0, "R7 no irq");
      chk(irq_status == 1'b1, "R7 status with irq off", 64'(irq_status), 64'd1);
      chk(irq == 1'b0, "R7 irq masked", 64'(irq), 64'd0);
      @(negedge clk); cfg_irq_en = 1'b1; #0.5;
      chk(irq == 1'b1, "R7 irq unmasked", 64'(irq), 64'd1);
      pulse_clear();
   endtask

   task automatic t_count();
      set_n(8'd3);
      send_chk(32'h11, 4'd1, 1'b0, "R5 a");
      send_chk(32'h22, 4'd1, 1'b0, "R5 b");
      chk(irq_status == 1'b0, "R5 below threshold", 64'(irq_status), 64'd0);
      send_chk(32'h33, 4'd1, 1'b0, "R5 c");
      chk(irq_status == 1'b1, "R5 threshold reached", 64'(irq_status), 64'd1);
      pulse_clear();
      send_chk(32'h44, 4'd1, 1'b0, "R5 d");
      chk(irq_status == 1'b0, "R5 counter restarted on fire", 64'(irq_status), 64'd0);
      set_n(8'd3);
      send_chk(32'h55, 4'd1, 1'b0, "R5 e");
      send_chk(32'h66, 4'd1, 1'b0, "R5 f");
      chk(irq_status == 1'b0, "R5 counter restarted on load", 64'(irq_status), 64'd0);
      send_chk(32'h77, 4'd1, 1'b0, "R5 g");
      chk(irq_status == 1'b1, "R5 fire after load", 64'(irq_status), 64'd1);
   endtask

   task automatic t_clear_race();
      set_n(8'd1);
      pulse_clear();
      chk(irq_status == 1'b0, "R6 cleared", 64'(irq_status), 64'd0);
      send(32'h88, 4'd4, 1'b0, 1'b1);
      exp_wp = (exp_wp + 1) % depth;
      chk(irq_status == 1'b1, "R6 set wins over clear", 64'(irq_status), 64'd1);
      pulse_clear();
      chk(irq_status == 1'b0, "R6 write-one clear", 64'(irq_status), 64'd0);
   endtask

   task automatic t_unsol();
      int wr0;
      cfg_accept_unsol = 1'b0;
      @(negedge clk);
      wr0 = n_wr;
      send(32'h9999, 4'd6, 1'b1, 1'b0);
      @(negedge clk);
      chk(wr_ptr == PTR_W'(exp_wp), "R8 pointer unchanged", 64'(wr_ptr), 64'(exp_wp));
      chk(n_wr == wr0, "R8 no memory write", 64'(n_wr), 64'(wr0));
      chk(irq_status == 1'b0, "R8 not counted", 64'(irq_status), 64'd0);
      send_chk(32'hAAAA, 4'd6, 1'b0, "R8 solicited still stored");
      cfg_accept_unsol = 1'b1;
      pulse_clear();
   endtask

   task automatic t_wp_reset();
      reset_ptr();
      send_chk(32'hB00B, 4'd7, 1'b0, "R4 first after reset");
      chk(mem_wr_addr == BASE + 32'd8, "R4 entry one", 64'(mem_wr_addr), 64'(BASE + 32'd8));
   endtask

   task automatic t_wrap();
      cfg_size = 2'd0; depth = 2;
      reset_ptr();
      send_chk(32'h1, 4'd0, 1'b0, "R3 two-ring 1");
      send_chk(32'h2, 4'd0, 1'b0, "R3 two-ring wrap");
      chk(wr_ptr == '0, "R3 two-ring at zero", 64'(wr_ptr), 64'd0);
      send_chk(32'h3, 4'd0, 1'b0, "R3 two-ring 3");
      cfg_size = 2'd1; depth = 16;
      reset_ptr();
      for (int i = 0; i < 15; i++) send_chk(32'(i), 4'd0, 1'b0, "R3 sixteen-ring");
      chk(wr_ptr == 8'd15, "R3 sixteen-ring top", 64'(wr_ptr), 64'd15);
      send_chk(32'hF0, 4'd0, 1'b0, "R3 sixteen-ring wrap");
      chk(wr_ptr == '0, "R3 sixteen-ring at zero", 64'(wr_ptr), 64'd0);
      cfg_size = 2'd2; depth = 256;
      reset_ptr();
      pulse_clear();
   endtask

   task automatic t_dma_off();
      int wr0;
      @(negedge clk);
      cfg_dma_en = 1'b0;
      rsp_data = 32'hD0D0_0001; rsp_codec = 4'd9; rsp_unsol = 1'b0; rsp_valid = 1'b1;
      wr0 = n_wr;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(rsp_ready == 1'b0, "R9 ready low when disabled", 64'(rsp_ready), 64'd0);
      end
      chk(n_wr == wr0, "R9 nothing written when disabled", 64'(n_wr), 64'(wr0));
      cfg_dma_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      exp_wp = (exp_wp + 1) % depth;
      chk(mem_wr_data == entry(32'hD0D0_0001, 4'd9, 1'b0), "R9 held response delivered", mem_wr_data, entry(32'hD0D0_0001, 4'd9, 1'b0));
      chk(wr_ptr == PTR_W'(exp_wp), "R9 pointer after enable", 64'(wr_ptr), 64'(exp_wp));
      pulse_clear();
   endtask

   task automatic t_mem_stall();
      logic [31:0] a0;
      mem_wr_ready = 1'b0;
      send_chk(32'h5151_0000, 4'd5, 1'b0, "R10 first");
      a0 = mem_wr_addr;
      rsp_data = 32'h5252_0000; rsp_codec = 4'd5; rsp_unsol = 1'b0; rsp_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(rsp_ready == 1'b0, "R10 ready low during stall", 64'(rsp_ready), 64'd0);
         chk(mem_wr_addr == a0, "R10 address held", 64'(mem_wr_addr), 64'(a0));
         chk(mem_wr_data == entry(32'h5151_0000, 4'd5, 1'b0), "R10 data held", mem_wr_data, entry(32'h5151_0000, 4'd5, 1'b0));
      end
      mem_wr_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      exp_wp = (exp_wp + 1) % depth;
      chk(mem_wr_data == entry(32'h5252_0000, 4'd5, 1'b0), "R10 second after stall", mem_wr_data, entry(32'h5252_0000, 4'd5, 1'b0));
      chk(wr_ptr == PTR_W'(exp_wp), "R10 pointer after stall", 64'(wr_ptr), 64'(exp_wp));
      pulse_clear();
   endtask

   task automatic t_full_count();
      set_n(8'd0);
      pulse_clear();
      for (int i = 0; i < 255; i++) send(32'(i), 4'd1, 1'b0, 1'b0);
      exp_wp = (exp_wp + 255) % depth;
      chk(irq_status == 1'b0, "R5 zero threshold not yet", 64'(irq_status), 64'd0);
      send(32'hFFFF, 4'd1, 1'b0, 1'b0);
      exp_wp = (exp_wp + 1) % depth;
      chk(irq_status == 1'b1, "R5 zero threshold is 256", 64'(irq_status), 64'd1);
      chk(wr_ptr == PTR_W'(exp_wp), "R3 full ring wrap", 64'(wr_ptr), 64'(exp_wp));
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_irq_enable();
      t_count();
      t_clear_race();
      t_unsol();
      t_wp_reset();
      t_wrap();
      t_dma_off();
      t_mem_stall();
      t_full_count();
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule